// File: doc/BRIEF.md
# Inbound Message Frame Queue Pointer Unit

This unit tracks a circular queue of fixed-size message frames that sit in memory. It holds two 32-bit frame addresses. The receive side moves the enqueue address forward each time it deposits a frame. Software moves the dequeue address forward after it has consumed a frame. Both addresses step by one frame size and wrap inside an aligned window whose size is the entry count times the frame size. Only the offset bits inside that window ever change during an advance.

Software reaches the unit through a small register port. It first sets the queue geometry in a control register. It then loads both addresses with a frame slot inside the aligned window. After handling a frame, it sets a self-clearing advance bit. The unit drives empty and full flags for the reader and the writer. It also presents both addresses directly on output ports.

Top module: `ifq_frame_ptrs`

## Requirements
- R1: After reset, both addresses and the control register read as zero, `empty_o` is 1 and `full_o` is 0.
- R2: Register map: address 0 is control, address 1 is the dequeue address, address 2 is the enqueue address, and address 3 reads zero. Writes take effect at the clock edge. Reads are combinational. Bits 2:0 of both addresses always read zero, and writes to those bits are ignored.
- R3: Control bit 0 is the advance bit. When it is written as 1 and the queue is not empty, the dequeue address moves forward by one frame at the next edge, and the bit reads 0 from then on.
- R4: An advance adds the frame size only to the bits below log2(entries × frame size). The bits above that stay fixed, so the step after the last slot lands on the window base.
- R5: `empty_o` is 1 exactly when the two addresses are equal. An advance bit that is set while the queue is empty leaves the dequeue address unchanged and still reads 0 one cycle later.
- R6: A one-cycle pulse on `enq_stb_i` moves the enqueue address forward by one frame at that clock edge, using the same wrap rule as R4.
- R7: `full_o` is 1 exactly when one more enqueue step would make the enqueue address equal to the dequeue address. A pulse on `enq_stb_i` while full is ignored. Full and empty are never both 1.
- R8: An enqueue pulse and a pending advance in the same cycle both take effect. Each one uses the full and empty state from before that edge.
- R9: Control bits 7:4 hold the queue code q, giving 2^(q+1) entries. Codes above 10 act as 10. Control bits 11:8 hold the frame code f, giving 2^(f+3) bytes per frame. Codes above 9 act as 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 2 | Register select |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| enq_stb_i | input | 1 | One-cycle pulse: the receive side has stored a frame |
| deq_ptr_o | output | 32 | Current dequeue frame address |
| enq_ptr_o | output | 32 | Current enqueue frame address |
| empty_o | output | 1 | Queue empty |
| full_o | output | 1 | Queue full |

## Verification
- Register writes and enqueue pulses take effect at the edge on which they are sampled. The bench drives inputs on the falling edge and reads the result on the next falling edge.
- The advance bit is captured at one edge and acted on at the following edge. Every advance check therefore waits one extra cycle after the control write before it compares the dequeue address.
- Read data and the flags come straight from registers through combinational logic. The bench samples them 1 ns after it sets the address, on a falling edge.

// File: rtl/ifq_pkg.sv
package ifq_pkg;
  typedef enum logic [1:0] {
    RA_CTRL = 2'd0,
    RA_DEQ  = 2'd1,
    RA_ENQ  = 2'd2,
    RA_NONE = 2'd3
  } reg_addr_e;

  localparam int unsigned CTRL_INC_BIT = 0;
  localparam int unsigned CTRL_Q_LSB   = 4;
  localparam int unsigned CTRL_F_LSB   = 8;
  localparam int unsigned CODE_W       = 4;
  localparam int unsigned RSV_LSBS     = 3;
endpackage

// File: rtl/ifq_geom.sv
module ifq_geom #(
  parameter int unsigned PTR_W  = 32,
  parameter int unsigned CODE_W = 4,
  parameter int unsigned Q_MAX  = 10,
  parameter int unsigned F_MAX  = 9
) (
  input  logic [CODE_W-1:0] q_code_i,
  input  logic [CODE_W-1:0] f_code_i,
  output logic [PTR_W-1:0]  step_o,
  output logic [PTR_W-1:0]  mask_o
);
  int unsigned q_eff, f_eff, f_log, w_log;

  always_comb begin
    q_eff  = (32'(q_code_i) > Q_MAX) ? Q_MAX : 32'(q_code_i);
    f_eff  = (32'(f_code_i) > F_MAX) ? F_MAX : 32'(f_code_i);
    f_log  = f_eff + 3;
    w_log  = q_eff + 1 + f_log;
    step_o = PTR_W'(1) << f_log;
    mask_o = (PTR_W'(1) << w_log) - PTR_W'(1);
  end
endmodule

// File: rtl/ifq_ptr_step.sv
module ifq_ptr_step #(
  parameter int unsigned PTR_W = 32
) (
  input  logic [PTR_W-1:0] ptr_i,
  input  logic [PTR_W-1:0] step_i,
  input  logic [PTR_W-1:0] mask_i,
  output logic [PTR_W-1:0] nxt_o
);
  logic [PTR_W-1:0] sum;
  assign sum   = ptr_i + step_i;
  // only window offset bits move; carry out of the window is dropped
  assign nxt_o = (ptr_i & ~mask_i) | (sum & mask_i);
endmodule

// File: rtl/ifq_ptr_reg.sv
module ifq_ptr_reg #(
  parameter int unsigned PTR_W = 32,
  parameter int unsigned RSV   = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [PTR_W-1:RSV] wdata_i,
  input  logic               adv_i,
  input  logic [PTR_W-1:0]   nxt_i,
  output logic [PTR_W-1:0]   ptr_o
);
  logic [PTR_W-1:RSV] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_q <= '0;
    else if (wr_i)  ptr_q <= wdata_i;
    else if (adv_i) ptr_q <= nxt_i[PTR_W-1:RSV];
  end

  assign ptr_o = {ptr_q, {RSV{1'b0}}};

  logic unused_nxt;
  assign unused_nxt = ^nxt_i[RSV-1:0];
endmodule

// File: rtl/ifq_frame_ptrs.sv
module ifq_frame_ptrs
  import ifq_pkg::*;
#(
  parameter int unsigned PTR_W = 32,
  parameter int unsigned Q_MAX = 10,
  parameter int unsigned F_MAX = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [1:0]       reg_addr_i,
  input  logic [PTR_W-1:0] reg_wdata_i,
  output logic [PTR_W-1:0] reg_rdata_o,
  input  logic             enq_stb_i,
  output logic [PTR_W-1:0] deq_ptr_o,
  output logic [PTR_W-1:0] enq_ptr_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam int unsigned NPTR   = 2;
  localparam int unsigned IDX_D  = 0;
  localparam int unsigned IDX_E  = 1;
  localparam int unsigned CTRL_W = CTRL_F_LSB + CODE_W;

  logic              inc_q;
  logic [CODE_W-1:0] q_code_q, f_code_q;
  logic [PTR_W-1:0]  step, mask;
  logic [PTR_W-1:0]  ptr   [NPTR];
  logic [PTR_W-1:0]  nxt   [NPTR];
  logic [NPTR-1:0]   wr, adv;
  logic              ctrl_wr;

  assign ctrl_wr = reg_we_i && (reg_addr_e'(reg_addr_i) == RA_CTRL);
  assign wr[IDX_D] = reg_we_i && (reg_addr_e'(reg_addr_i) == RA_DEQ);
  assign wr[IDX_E] = reg_we_i && (reg_addr_e'(reg_addr_i) == RA_ENQ);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inc_q    <= 1'b0;
      q_code_q <= '0;
      f_code_q <= '0;
    end else if (ctrl_wr) begin
      inc_q    <= reg_wdata_i[CTRL_INC_BIT];
      q_code_q <= reg_wdata_i[CTRL_Q_LSB +: CODE_W];
      f_code_q <= reg_wdata_i[CTRL_F_LSB +: CODE_W];
    end else if (inc_q) begin
      inc_q    <= 1'b0;
    end
  end

  ifq_geom #(.PTR_W(PTR_W), .CODE_W(CODE_W), .Q_MAX(Q_MAX), .F_MAX(F_MAX)) u_geom (
    .q_code_i(q_code_q),
    .f_code_i(f_code_q),
    .step_o  (step),
    .mask_o  (mask)
  );

  assign empty_o = (ptr[IDX_D] == ptr[IDX_E]);
  assign full_o  = (nxt[IDX_E] == ptr[IDX_D]);

  assign adv[IDX_D] = inc_q && !empty_o;
  assign adv[IDX_E] = enq_stb_i && !full_o;

  for (genvar i = 0; i < NPTR; i++) begin : g_ptr
    ifq_ptr_step #(.PTR_W(PTR_W)) u_step (
      .ptr_i (ptr[i]),
      .step_i(step),
      .mask_i(mask),
      .nxt_o (nxt[i])
    );
    ifq_ptr_reg #(.PTR_W(PTR_W), .RSV(RSV_LSBS)) u_reg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (wr[i]),
      .wdata_i(reg_wdata_i[PTR_W-1:RSV_LSBS]),
      .adv_i  (adv[i]),
      .nxt_i  (nxt[i]),
      .ptr_o  (ptr[i])
    );
  end

  assign deq_ptr_o = ptr[IDX_D];
  assign enq_ptr_o = ptr[IDX_E];

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_e'(reg_addr_i))
      RA_CTRL: begin
        reg_rdata_o[CTRL_INC_BIT]          = inc_q;
        reg_rdata_o[CTRL_Q_LSB +: CODE_W]  = q_code_q;
        reg_rdata_o[CTRL_F_LSB +: CODE_W]  = f_code_q;
      end
      RA_DEQ:  reg_rdata_o = ptr[IDX_D];
      RA_ENQ:  reg_rdata_o = ptr[IDX_E];
      default: reg_rdata_o = '0;
    endcase
  end

  logic unused_wdata;
  assign unused_wdata = ^{reg_wdata_i[PTR_W-1:CTRL_W], reg_wdata_i[CTRL_Q_LSB-1:1]};
endmodule

// File: rtl/ifq_frame_ptrs_chk.sv
module ifq_frame_ptrs_chk #(
  parameter int unsigned PTR_W = 32,
  parameter int unsigned Q_MAX = 10,
  parameter int unsigned F_MAX = 9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_we_i,
  input logic [1:0]       reg_addr_i,
  input logic             enq_stb_i,
  input logic             inc_q,
  input logic [PTR_W-1:0] deq_ptr_o,
  input logic [PTR_W-1:0] enq_ptr_o,
  input logic             empty_o,
  input logic             full_o
);
  localparam int unsigned WIN_MAX = Q_MAX + 1 + F_MAX + 3;

  AST_RSV_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deq_ptr_o[2:0] == 3'b0 && enq_ptr_o[2:0] == 3'b0); // R2

  AST_INC_SELF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_q && !(reg_we_i && reg_addr_i == 2'd0) |=> !inc_q); // R3

  AST_UPPER_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_we_i |=> deq_ptr_o[PTR_W-1:WIN_MAX] == $past(deq_ptr_o[PTR_W-1:WIN_MAX])
              && enq_ptr_o[PTR_W-1:WIN_MAX] == $past(enq_ptr_o[PTR_W-1:WIN_MAX])); // R4

  AST_EMPTY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_q && empty_o && !reg_we_i |=> $stable(deq_ptr_o)); // R5

  AST_FULL_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enq_stb_i && full_o && !reg_we_i |=> $stable(enq_ptr_o)); // R7

  AST_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(empty_o && full_o)); // R7
endmodule

bind ifq_frame_ptrs ifq_frame_ptrs_chk #(.PTR_W(PTR_W), .Q_MAX(Q_MAX), .F_MAX(F_MAX)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .reg_we_i  (reg_we_i),
  .reg_addr_i(reg_addr_i),
  .enq_stb_i (enq_stb_i),
  .inc_q     (inc_q),
  .deq_ptr_o (deq_ptr_o),
  .enq_ptr_o (enq_ptr_o),
  .empty_o   (empty_o),
  .full_o    (full_o)
);

// File: tb/ifq_frame_ptrs_tb.sv
`timescale 1ns/1ps
module ifq_frame_ptrs_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_addr_i = 2'd0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        enq_stb_i = 1'b0;
  logic [31:0] deq_ptr_o, enq_ptr_o;
  logic        empty_o, full_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  ifq_frame_ptrs u_dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] p, input int q, input int f);
    longint win, fs, off;
    if (q > 10) q = 10;
    if (f > 9) f = 9;
    fs  = longint'(1) << (f + 3);
    win = (longint'(1) << (q + 1)) * fs;
    off = longint'(p) % win;
    return 32'(longint'(p) - off + (off + fs) % win);
  endfunction

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk_i);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic push();
    @(negedge clk_i); enq_stb_i = 1'b1;
    @(negedge clk_i); enq_stb_i = 1'b0;
  endtask

  task automatic do_inc(input logic [31:0] mode);
    wr(2'd0, mode | 32'd1);
    @(negedge clk_i);
  endtask

  initial begin
    #(5ns * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, base, start, exp_e, exp_d, mode;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    rd(2'd0, r); chk(r == 0, "R1 ctrl", r, 0);
    rd(2'd1, r); chk(r == 0, "R1 deq", r, 0);
    rd(2'd2, r); chk(r == 0, "R1 enq", r, 0);
    chk(empty_o && !full_o, "R1 flags", {empty_o, full_o}, 32'd2);
    // R2 reserved bits and map
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, r); chk(r == 32'hFFFF_FFF8, "R2 deq rsv", r, 32'hFFFF_FFF8);
    wr(2'd2, 32'hA5A5_A5A7);
    rd(2'd2, r); chk(r == 32'hA5A5_A5A0, "R2 enq rsv", r, 32'hA5A5_A5A0);
    rd(2'd3, r); chk(r == 0, "R2 addr3", r, 0);

    // exhaustive small-geometry sweep: R3 R4 R5 R6 R7 R9
    for (int q = 0; q < 3; q++) begin
      for (int f = 0; f < 3; f++) begin
        int ent, fs;
        ent = 2 ** (q + 1); fs = 2 ** (f + 3);
        base  = 32'h1234_0000;
        start = base + 32'((ent - 1) * fs);
        mode  = 32'((f << 8) | (q << 4));
        wr(2'd0, mode); wr(2'd1, start); wr(2'd2, start);
        rd(2'd0, r); chk(r == mode, "R9 ctrl fields", r, mode);
        chk(empty_o && !full_o, "R5 empty after load", {empty_o, full_o}, 32'd2);
        exp_e = start;
        for (int k = 1; k < ent; k++) begin
          push();
          exp_e = nxt(exp_e, q, f);
          chk(enq_ptr_o == exp_e, "R6 R4 enq step", enq_ptr_o, exp_e);
          chk(full_o == (k == ent - 1), "R7 full flag", full_o, (k == ent - 1));
          chk(!empty_o, "R5 not empty", empty_o, 0);
        end
        push();
        chk(enq_ptr_o == exp_e, "R7 push while full", enq_ptr_o, exp_e);
        exp_d = start;
        for (int k = 1; k < ent; k++) begin
          do_inc(mode);
          exp_d = nxt(exp_d, q, f);
          chk(deq_ptr_o == exp_d, "R3 R4 deq step", deq_ptr_o, exp_d);
          chk(empty_o == (k == ent - 1), "R5 empty flag", empty_o, (k == ent - 1));
          rd(2'd0, r); chk(r[0] == 1'b0, "R3 inc cleared", r, mode);
        end
        do_inc(mode);
        chk(deq_ptr_o == exp_d, "R5 inc while empty", deq_ptr_o, exp_d);
        rd(2'd0, r); chk(r[0] == 1'b0, "R5 inc cleared when empty", r, mode);
      end
    end

    // R9 clamp of out-of-range codes, R4 wrap at top of largest window
    mode = 32'h0000_0FF0;
    wr(2'd0, mode); wr(2'd1, 32'h12FF_F000); wr(2'd2, 32'h1280_0000);
    do_inc(mode);
    chk(deq_ptr_o == nxt(32'h12FF_F000, 15, 15), "R9 R4 clamp wrap", deq_ptr_o, 32'h1280_0000);
    chk(empty_o, "R9 empty after wrap", empty_o, 1);

    // R8 simultaneous: 4 entries of 8 bytes
    mode = 32'h0000_0010;
    base = 32'h0000_2000;
    wr(2'd0, mode); wr(2'd1, base); wr(2'd2, base);
    push();
    wr(2'd0, mode | 32'd1);
    enq_stb_i = 1'b1;
    @(negedge clk_i); enq_stb_i = 1'b0;
    chk(enq_ptr_o == base + 32'd16, "R8 enq both", enq_ptr_o, base + 32'd16);
    chk(deq_ptr_o == base + 32'd8, "R8 deq both", deq_ptr_o, base + 32'd8);
    // full and both: enqueue uses old full state and is dropped
    push(); push();
    chk(full_o, "R7 full before both", full_o, 1);
    wr(2'd0, mode | 32'd1);
    enq_stb_i = 1'b1;
    @(negedge clk_i); enq_stb_i = 1'b0;
    chk(enq_ptr_o == base, "R8 enq dropped when full", enq_ptr_o, base);
    chk(deq_ptr_o == base + 32'd16, "R8 deq still moves", deq_ptr_o, base + 32'd16);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule